// File: doc/BRIEF.md
# Acknowledge-Polling Two-Wire Master Sequencer

This block is a small master for a two-wire open-drain bus. It finds out when a serial memory has finished its internal write cycle. The memory stays silent while that cycle runs. The block therefore sends a START and a write-type control byte, then watches the ninth (acknowledge) clock. A missing acknowledge means the memory is still busy. The block then closes the attempt with a STOP, leaves the bus free for a full bit period and tries again.

A host asserts a one-cycle request once it has issued the STOP that launched the write. It supplies four values with the request:
- the 3-bit chip-select value;
- the half bit period in clock cycles;
- a retry limit;
- a flag that chooses whether a successful poll keeps the bus for a chained command or releases it with a STOP.

The block latches these values when it accepts the request. When the poll finishes it returns a one-cycle done pulse or a one-cycle timeout pulse. Both bus lines are driven only by pulling them low. Each `*_oe_o` output high means "drive the line low".

Top module: `ackpoll_master`

## Requirements
- R1: While reset is active, and in the first cycle after it, scl_oe_o, sda_oe_o, busy_o, done_o and timeout_o are all 0.
- R2: Each attempt has the following phases, in order. Each phase is H clock cycles long, where H = max(half_per_i, 1).
  - Both lines are released.
  - SDA is pulled low while SCL stays released (START).
  - Eight bits follow, most significant first. Each bit is one phase with SCL pulled low and then one phase with SCL released.
  - The byte is binary 1010, then chip-select bits [2:0], then a 0 (write). SDA is pulled low for each 0 bit and released for each 1 bit.
- R3: Outside the START edge and the STOP edge, SDA never changes while SCL is released in both the previous and the current cycle.
- R4: During the ninth bit SDA is released. sda_i is sampled in the last cycle of that bit's SCL-released phase. Low means acknowledge; high means busy.
- R5: On a busy answer the master sends a STOP before any retry:
  - SDA low with SCL low for H cycles;
  - SCL released with SDA low for H cycles;
  - both lines released for 2H cycles of bus-free time.
  The next attempt then starts at its first phase.
- R6: If an acknowledge arrives and the latched hold flag is 0, the master sends the same STOP and 2H bus-free phase. It then pulses done_o in the first idle cycle.
- R7: If an acknowledge arrives and the latched hold flag is 1, the master skips the STOP. It pulses done_o and keeps SCL pulled low with SDA released. It stays that way until the next request, and that request starts with a repeated START from the both-released phase.
- R8: After max(try_lim_i, 1) attempts without an acknowledge, the master ends the last attempt with STOP and bus-free time. It then pulses timeout_o and returns to idle with both lines released, and starts no further attempt.
- R9: Chip select, half period, retry limit and hold flag are captured when a request is accepted. Changing them during a poll has no effect on it.
- R10: A request asserted while busy_o is 1 is ignored.
- R11: busy_o is 1 from the cycle after an accepted request until the cycle in which done_o or timeout_o pulses; in that cycle busy_o is 0. done_o and timeout_o each last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle poll request |
| chip_sel_i | input | 3 | Chip-select bits placed in the control byte |
| hold_bus_i | input | 1 | 1: keep the bus after success; 0: send STOP |
| half_per_i | input | HALF_W | Half bit period in clock cycles (0 is treated as 1) |
| try_lim_i | input | TRY_W | Maximum number of attempts (0 is treated as 1) |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | Acknowledge received (pulse) |
| timeout_o | output | 1 | Retry limit reached (pulse) |

## Verification
The bench builds the block with HALF_W = 4 and TRY_W = 3. This brings the full ranges of both period and limit within reach: zero values that fall back to one, a limit of seven attempts, and the longest half period of fifteen cycles. A behavioural slave that answers busy for a chosen number of attempts drives the acknowledge. With it the bench covers:
- success on the first attempt;
- success after retries;
- timeout at a limit of one and at a limit of three;
- the held-bus ending, followed by a repeated-START poll.

One run changes every configuration input and raises a second request mid-poll, to show that neither affects the waveform.

// File: rtl/ackpoll_master.sv
module ackpoll_master #(
  parameter int HALF_W = 8,
  parameter int TRY_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        chip_sel_i,
  input  logic              hold_bus_i,
  input  logic [HALF_W-1:0] half_per_i,
  input  logic [TRY_W-1:0]  try_lim_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD, ST_STA, ST_STB, ST_LO, ST_HI, ST_SPA, ST_SPB, ST_GAP
  } state_t;

  state_t              state_q;
  logic [HALF_W:0]     cnt_q;
  logic [3:0]          bit_q;
  logic [TRY_W-1:0]    tries_q;
  logic [HALF_W-1:0]   half_q;
  logic [TRY_W-1:0]    lim_q;
  logic [2:0]          cs_q;
  logic                hold_q;
  logic                acked_q;
  logic                done_q;
  logic                tmo_q;

  logic [HALF_W-1:0]   half_eff;
  logic [TRY_W-1:0]    lim_eff;
  logic [HALF_W:0]     phase_len;
  logic                tick;
  logic [7:0]          ctrl_byte;
  logic                cur_bit;
  logic                last_try;
  logic                idle_like;

  assign half_eff  = (half_q == '0) ? HALF_W'(1) : half_q;
  assign lim_eff   = (lim_q == '0) ? TRY_W'(1) : lim_q;
  assign phase_len = (state_q == ST_GAP) ? {half_eff, 1'b0} : {1'b0, half_eff};
  assign tick      = (cnt_q == phase_len - (HALF_W+1)'(1));
  assign ctrl_byte = {4'b1010, cs_q, 1'b0};
  assign cur_bit   = bit_q[3] ? 1'b1 : ctrl_byte[~bit_q[2:0]];
  assign last_try  = ({1'b0, tries_q} + (TRY_W+1)'(1)) >= {1'b0, lim_eff};
  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_HOLD);

  assign scl_oe_o  = (state_q == ST_LO) || (state_q == ST_SPA) || (state_q == ST_HOLD);
  assign sda_oe_o  = (state_q == ST_STB) || (state_q == ST_SPA) || (state_q == ST_SPB) ||
                     (((state_q == ST_LO) || (state_q == ST_HI)) && !cur_bit);
  assign busy_o    = !idle_like;
  assign done_o    = done_q;
  assign timeout_o = tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      tries_q <= '0;
      half_q  <= '0;
      lim_q   <= '0;
      cs_q    <= '0;
      hold_q  <= 1'b0;
      acked_q <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      if (idle_like) begin
        if (start_i) begin
          state_q <= ST_STA;
          cnt_q   <= '0;
          tries_q <= '0;
          half_q  <= half_per_i;
          lim_q   <= try_lim_i;
          cs_q    <= chip_sel_i;
          hold_q  <= hold_bus_i;
          acked_q <= 1'b0;
        end
      end else if (!tick) begin
        cnt_q <= cnt_q + (HALF_W+1)'(1);
      end else begin
        cnt_q <= '0;
        unique case (state_q)
          ST_STA: state_q <= ST_STB;
          ST_STB: begin
            state_q <= ST_LO;
            bit_q   <= '0;
          end
          ST_LO:  state_q <= ST_HI;
          ST_HI: begin
            if (bit_q == 4'd8) begin
              if (!sda_i && hold_q) begin
                state_q <= ST_HOLD;
                done_q  <= 1'b1;
              end else begin
                acked_q <= !sda_i;
                state_q <= ST_SPA;
              end
            end else begin
              bit_q   <= bit_q + 4'd1;
              state_q <= ST_LO;
            end
          end
          ST_SPA: state_q <= ST_SPB;
          ST_SPB: state_q <= ST_GAP;
          ST_GAP: begin
            if (acked_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else if (last_try) begin
              state_q <= ST_IDLE;
              tmo_q   <= 1'b1;
            end else begin
              tries_q <= tries_q + TRY_W'(1);
              state_q <= ST_STA;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_sda_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_o && $past(!scl_oe_o) && (sda_oe_o != $past(sda_oe_o)))
      |-> (state_q == ST_STB || state_q == ST_GAP));

  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_tmo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!busy_o && !scl_oe_o && !sda_oe_o));

  assert_hold_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> (scl_oe_o && !sda_oe_o && !busy_o));

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && state_q != ST_GAP) |=> busy_o);

  assert_stop_before_retry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_GAP && state_q == ST_STA) |-> $past(!acked_q));

endmodule

// File: tb/ackpoll_master_tb_top.sv
`timescale 1ns/1ps
module ackpoll_master_tb_top;
  localparam int HW = 4;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] chip_sel_i = '0;
  logic hold_bus_i = 1'b0;
  logic [HW-1:0] half_per_i = '0;
  logic [TW-1:0] try_lim_i = '0;
  logic slave_pull = 1'b0;
  logic sda_line;
  logic scl_oe_o, sda_oe_o, busy_o, done_o, timeout_o;

  int total = 0;
  int bad = 0;
  logic [5:0] expq[$];
  logic [5:0] rest_e = 6'b000000;

  always #2 clk = ~clk;

  assign sda_line = !(sda_oe_o || slave_pull);

  ackpoll_master #(.HALF_W(HW), .TRY_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chip_sel_i(chip_sel_i),
    .hold_bus_i(hold_bus_i), .half_per_i(half_per_i), .try_lim_i(try_lim_i),
    .sda_i(sda_line), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o));

  // entry: {scl, sda, pull, done, tmo, busy}
  task automatic push(input logic s, input logic d, input logic p, input logic dn,
                      input logic tm, input logic b, input int n);
    for (int i = 0; i < n; i++) expq.push_back({s, d, p, dn, tm, b});
  endtask

  task automatic plan(input logic [2:0] cs, input int hp, input int lim,
                      input logic hold, input int nbusy);
    int h = (hp == 0) ? 1 : hp;
    int l = (lim == 0) ? 1 : lim;
    logic [7:0] cb = {4'b1010, cs, 1'b0};
    for (int a = 0; a < 64; a++) begin
      logic ack = (a >= nbusy);
      push(0, 0, 0, 0, 0, 1, h);
      push(0, 1, 0, 0, 0, 1, h);
      for (int b = 7; b >= 0; b--) begin
        push(1, !cb[b], 0, 0, 0, 1, h);
        push(0, !cb[b], 0, 0, 0, 1, h);
      end
      push(1, 0, ack, 0, 0, 1, h);
      push(0, 0, ack, 0, 0, 1, h);
      if (ack && hold) begin
        rest_e = 6'b100000;
        push(1, 0, 0, 1, 0, 0, 1);
        push(1, 0, 0, 0, 0, 0, 3);
        break;
      end
      push(1, 1, 0, 0, 0, 1, h);
      push(0, 1, 0, 0, 0, 1, h);
      push(0, 0, 0, 0, 0, 1, 2*h);
      if (ack || (a + 1 >= l)) begin
        rest_e = 6'b000000;
        push(0, 0, 0, ack, !ack, 0, 1);
        push(0, 0, 0, 0, 0, 0, 3);
        break;
      end
    end
  endtask

  task automatic run(input string tag, input logic [2:0] cs, input int hp, input int lim,
                     input logic hold, input int nbusy, input bit disturb);
    int idx = 0;
    int fails = 0;
    plan(cs, hp, lim, hold, nbusy);
    @(negedge clk);
    chip_sel_i = cs; half_per_i = HW'(hp); try_lim_i = TW'(lim); hold_bus_i = hold;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (expq.size() > 0) begin
      logic [5:0] e = expq.pop_front();
      logic [4:0] act = {scl_oe_o, sda_oe_o, done_o, timeout_o, busy_o};
      logic [4:0] exp5 = {e[5], e[4], e[2], e[1], e[0]};
      total++;
      if (act !== exp5) begin
        bad++;
        fails++;
        if (fails < 6)
          $display("FAIL %s cycle %0d: {scl,sda,done,tmo,busy} actual=%b expected=%b",
                   tag, idx, act, exp5);
      end
      slave_pull = e[3];
      if (disturb && idx == 6) begin
        start_i = 1'b1;
        chip_sel_i = ~cs; half_per_i = HW'(hp + 3); try_lim_i = TW'(lim + 2);
        hold_bus_i = !hold;
      end else begin
        start_i = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    slave_pull = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({scl_oe_o, sda_oe_o, busy_o, done_o, timeout_o} !== 5'b0) begin
      bad++;
      $display("FAIL R1 in reset: actual=%b expected=00000",
               {scl_oe_o, sda_oe_o, busy_o, done_o, timeout_o});
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if ({scl_oe_o, sda_oe_o, busy_o, done_o, timeout_o} !== 5'b0) begin
      bad++;
      $display("FAIL R1 after reset: actual=%b expected=00000",
               {scl_oe_o, sda_oe_o, busy_o, done_o, timeout_o});
    end
    run("R2 R3 R4 R5 R6 busy twice then ack", 3'b101, 2, 4, 1'b0, 2, 1'b0);
    run("R8 R9 zero limit and zero period", 3'b000, 0, 0, 1'b0, 1, 1'b0);
    run("R8 R11 timeout after three tries", 3'b111, 3, 3, 1'b0, 5, 1'b0);
    run("R7 R4 hold bus on first ack", 3'b010, 1, 7, 1'b1, 0, 1'b0);
    run("R7 R9 R10 repeated start with mid-poll disturbance", 3'b110, 2, 2, 1'b0, 1, 1'b1);
    run("R2 R6 R9 longest period", 3'b011, 15, 1, 1'b0, 0, 1'b0);
    run("R5 R11 seven-try limit reached on last", 3'b001, 1, 7, 1'b0, 6, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule